// File: doc/BRIEF.md
# RISC Instruction Decoder

This block turns a 32-bit instruction word into the control and operand-selection signals that an execute stage needs. It handles three word formats. The register format has a zero major opcode and an 11-bit function field. The immediate format has a 16-bit constant. The jump format has a 26-bit signed offset. From the word it derives the register indices to read and to write, the extended 32-bit constant, an internal ALU operation code, the memory read and write strobes, and a control-flow class for the next-PC logic.

The decoded result is captured in one register stage, so a word presented before a rising clock edge appears at the outputs just after that edge. The block has no register file, no ALU, no PC and no memory port. Those units read the outputs. An encoding the block does not know raises an illegal flag, and in that case the block never requests a register write or a memory access.

Top module: `isd_decoder`

## Requirements
- R1: All outputs come from a register that loads the decode of `instr_i` on each rising clock edge, so they change only after an edge. An asynchronous active-low reset clears every output to zero.
- R2: When bits 31:26 are 0, the write index is bits 25:21, source A is bits 20:16, source B is bits 15:11, the immediate is 0 and `use_imm_o` is 0. The ALU code comes from the whole 11-bit function field in bits 10:0: 0x020→1 add, 0x022→2 sub, 0x024→3 and, 0x025→4 or, 0x026→5 xor, 0x030→6 mul, 0x028→7 seq, 0x029→8 sne, 0x02A→9 slt, 0x02C→10 sle, 0x004→11 sll, 0x006→12 srl, 0x007→13 sra.
- R3: The immediate ALU opcodes map as follows: 0x08→1, 0x0A→2, 0x0C→3, 0x0D→4, 0x0E→5, 0x18→7, 0x19→8, 0x1A→9, 0x1C→10, 0x14→11, 0x16→12, 0x17→13. For these, the write index is bits 25:21, source A is bits 20:16, source B is 0 and `use_imm_o` is 1.
- R4: For the three logical immediate opcodes (0x0C, 0x0D, 0x0E), bits 15:0 are zero-extended. For every other immediate-format opcode that carries a constant, bits 15:0 are sign-extended.
- R5: Opcode 0x0F (load-high) gives ALU code 14 (pass B), an immediate equal to bits 15:0 shifted left by 16, source A = 0 and a write to bits 25:21.
- R6: Opcode 0x23 (load word) raises `mem_rd_o`, selects ALU code 1 with a sign-extended immediate and writes bits 25:21.
- R7: Opcode 0x2B (store word) raises `mem_wr_o`, reads bits 25:21 as source B and data, reads bits 20:16 as source A, selects ALU code 1 and writes no register. The two memory strobes are never high together.
- R8: Opcodes 0x04 and 0x05 give flow codes 1 (branch when zero) and 2 (branch when non-zero), with source A = bits 20:16 and a sign-extended immediate. They cause no register or memory write.
- R9: Opcodes 0x02 and 0x03 give flow code 3 (PC-relative jump) and sign-extend bits 25:0. Opcode 0x03 also writes register 31 with ALU code 15 (link).
- R10: Opcodes 0x12 and 0x13 give flow code 4 (jump to register) with source A = bits 20:16 and an immediate of 0. The destination field is ignored. Opcode 0x13 writes register 31 with ALU code 15, and opcode 0x12 writes nothing.
- R11: An undefined major opcode, or a register-format word whose 11-bit function field is not listed in R2, sets `illegal_o`. Every other output is then 0, including the write enable and both memory strobes.
- R12: An instruction that does not write a register shows a write index of 0. A write whose target index is 0 is suppressed (`reg_we_o` = 0), while any memory strobe of that instruction stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word to decode |
| wr_idx_o | output | 5 | Register index to write (0 when none) |
| src_a_idx_o | output | 5 | First source register index |
| src_b_idx_o | output | 5 | Second source register index (store data for stores) |
| imm_o | output | 32 | Extended immediate or offset |
| alu_op_o | output | 4 | Internal ALU operation code |
| use_imm_o | output | 1 | ALU second operand is the immediate |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| flow_o | output | 3 | Control-flow class: 0 none, 1 branch-zero, 2 branch-nonzero, 3 relative jump, 4 register jump |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
Every decoded field arrives exactly one rising edge after the word is presented. The decode logic has no state of its own, so there is no further latency. The bench changes `instr_i` on a falling edge and reads the outputs on the next falling edge, which places each sample half a period after the capturing edge. One directed test presents a second word and samples before the next rising edge, to show that the outputs still carry the first decode at that point. A reset asserted in the middle of a run is sampled shortly after its falling edge, because it clears the outputs without waiting for the clock.

// File: rtl/isd_pkg.sv
package isd_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned FN_W   = 11;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned OFF_W  = 26;
    localparam int unsigned ALU_W  = 4;
    localparam int unsigned FLOW_W = 3;

    typedef enum logic [ALU_W-1:0] {
        ALU_NOP  = 4'd0,
        ALU_ADD  = 4'd1,
        ALU_SUB  = 4'd2,
        ALU_AND  = 4'd3,
        ALU_OR   = 4'd4,
        ALU_XOR  = 4'd5,
        ALU_MUL  = 4'd6,
        ALU_SEQ  = 4'd7,
        ALU_SNE  = 4'd8,
        ALU_SLT  = 4'd9,
        ALU_SLE  = 4'd10,
        ALU_SLL  = 4'd11,
        ALU_SRL  = 4'd12,
        ALU_SRA  = 4'd13,
        ALU_PASS = 4'd14,
        ALU_LINK = 4'd15
    } alu_op_e;

    typedef enum logic [FLOW_W-1:0] {
        FL_SEQ  = 3'd0,
        FL_BZ   = 3'd1,
        FL_BNZ  = 3'd2,
        FL_JREL = 3'd3,
        FL_JREG = 3'd4
    } flow_e;

    typedef enum logic [2:0] {
        EXT_NONE  = 3'd0,
        EXT_S16   = 3'd1,
        EXT_Z16   = 3'd2,
        EXT_HI16  = 3'd3,
        EXT_S26   = 3'd4
    } ext_e;

    typedef enum logic [1:0] {
        SB_NONE = 2'd0,
        SB_RT   = 2'd1,
        SB_RD   = 2'd2
    } srcb_sel_e;

    typedef enum logic [1:0] {
        WD_NONE = 2'd0,
        WD_RD   = 2'd1,
        WD_LINK = 2'd2
    } wdst_sel_e;

    typedef struct packed {
        logic      legal;
        alu_op_e   alu;
        ext_e      ext;
        logic      use_imm;
        logic      sa_use;
        srcb_sel_e sb;
        wdst_sel_e wd;
        logic      mrd;
        logic      mwr;
        flow_e     flow;
    } ctrl_t;

    typedef struct packed {
        logic [RIDX_W-1:0] wr_idx;
        logic [RIDX_W-1:0] sa_idx;
        logic [RIDX_W-1:0] sb_idx;
        logic [XLEN-1:0]   imm;
        alu_op_e           alu;
        logic              use_imm;
        logic              we;
        logic              mrd;
        logic              mwr;
        flow_e             flow;
        logic              illegal;
    } dec_t;

endpackage

// File: rtl/isd_op_lookup.sv
module isd_op_lookup
    import isd_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [FN_W-1:0]  fn_i,
    output ctrl_t            ctrl_o
);

    function automatic ctrl_t mk(alu_op_e a, ext_e e, logic ui, logic sa,
                                 srcb_sel_e sb, wdst_sel_e wd,
                                 logic mr, logic mw, flow_e fl);
        ctrl_t c;
        c.legal   = 1'b1;
        c.alu     = a;
        c.ext     = e;
        c.use_imm = ui;
        c.sa_use  = sa;
        c.sb      = sb;
        c.wd      = wd;
        c.mrd     = mr;
        c.mwr     = mw;
        c.flow    = fl;
        return c;
    endfunction

    function automatic ctrl_t reg_op(alu_op_e a);
        return mk(a, EXT_NONE, 1'b0, 1'b1, SB_RT, WD_RD, 1'b0, 1'b0, FL_SEQ);
    endfunction

    function automatic ctrl_t imm_op(alu_op_e a, ext_e e);
        return mk(a, e, 1'b1, 1'b1, SB_NONE, WD_RD, 1'b0, 1'b0, FL_SEQ);
    endfunction

    ctrl_t rfmt_c;

    always_comb begin
        rfmt_c = '0;
        case (fn_i)
            11'h020: rfmt_c = reg_op(ALU_ADD);
            11'h022: rfmt_c = reg_op(ALU_SUB);
            11'h024: rfmt_c = reg_op(ALU_AND);
            11'h025: rfmt_c = reg_op(ALU_OR);
            11'h026: rfmt_c = reg_op(ALU_XOR);
            11'h030: rfmt_c = reg_op(ALU_MUL);
            11'h028: rfmt_c = reg_op(ALU_SEQ);
            11'h029: rfmt_c = reg_op(ALU_SNE);
            11'h02A: rfmt_c = reg_op(ALU_SLT);
            11'h02C: rfmt_c = reg_op(ALU_SLE);
            11'h004: rfmt_c = reg_op(ALU_SLL);
            11'h006: rfmt_c = reg_op(ALU_SRL);
            11'h007: rfmt_c = reg_op(ALU_SRA);
            default: rfmt_c = '0;
        endcase
    end

    always_comb begin
        ctrl_o = '0;
        case (opc_i)
            6'h00: ctrl_o = rfmt_c;
            6'h08: ctrl_o = imm_op(ALU_ADD, EXT_S16);
            6'h0A: ctrl_o = imm_op(ALU_SUB, EXT_S16);
            6'h0C: ctrl_o = imm_op(ALU_AND, EXT_Z16);
            6'h0D: ctrl_o = imm_op(ALU_OR,  EXT_Z16);
            6'h0E: ctrl_o = imm_op(ALU_XOR, EXT_Z16);
            6'h18: ctrl_o = imm_op(ALU_SEQ, EXT_S16);
            6'h19: ctrl_o = imm_op(ALU_SNE, EXT_S16);
            6'h1A: ctrl_o = imm_op(ALU_SLT, EXT_S16);
            6'h1C: ctrl_o = imm_op(ALU_SLE, EXT_S16);
            6'h14: ctrl_o = imm_op(ALU_SLL, EXT_S16);
            6'h16: ctrl_o = imm_op(ALU_SRL, EXT_S16);
            6'h17: ctrl_o = imm_op(ALU_SRA, EXT_S16);
            6'h0F: ctrl_o = mk(ALU_PASS, EXT_HI16, 1'b1, 1'b0, SB_NONE, WD_RD,
                               1'b0, 1'b0, FL_SEQ);
            6'h23: ctrl_o = mk(ALU_ADD, EXT_S16, 1'b1, 1'b1, SB_NONE, WD_RD,
                               1'b1, 1'b0, FL_SEQ);
            6'h2B: ctrl_o = mk(ALU_ADD, EXT_S16, 1'b1, 1'b1, SB_RD, WD_NONE,
                               1'b0, 1'b1, FL_SEQ);
            6'h04: ctrl_o = mk(ALU_NOP, EXT_S16, 1'b0, 1'b1, SB_NONE, WD_NONE,
                               1'b0, 1'b0, FL_BZ);
            6'h05: ctrl_o = mk(ALU_NOP, EXT_S16, 1'b0, 1'b1, SB_NONE, WD_NONE,
                               1'b0, 1'b0, FL_BNZ);
            6'h02: ctrl_o = mk(ALU_NOP, EXT_S26, 1'b0, 1'b0, SB_NONE, WD_NONE,
                               1'b0, 1'b0, FL_JREL);
            6'h03: ctrl_o = mk(ALU_LINK, EXT_S26, 1'b0, 1'b0, SB_NONE, WD_LINK,
                               1'b0, 1'b0, FL_JREL);
            6'h12: ctrl_o = mk(ALU_NOP, EXT_NONE, 1'b0, 1'b1, SB_NONE, WD_NONE,
                               1'b0, 1'b0, FL_JREG);
            6'h13: ctrl_o = mk(ALU_LINK, EXT_NONE, 1'b0, 1'b1, SB_NONE, WD_LINK,
                               1'b0, 1'b0, FL_JREG);
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/isd_imm_ext.sv
module isd_imm_ext
    import isd_pkg::*;
#(
    parameter int unsigned W_OUT = XLEN,
    parameter int unsigned W_IMM = IMM_W,
    parameter int unsigned W_OFF = OFF_W
) (
    input  logic [W_OFF-1:0] raw_i,
    input  ext_e             ext_i,
    output logic [W_OUT-1:0] imm_o
);

    localparam int unsigned PAD_IMM = W_OUT - W_IMM;
    localparam int unsigned PAD_OFF = W_OUT - W_OFF;

    logic [W_IMM-1:0] low_w;
    assign low_w = raw_i[W_IMM-1:0];

    always_comb begin
        case (ext_i)
            EXT_S16:  imm_o = {{PAD_IMM{low_w[W_IMM-1]}}, low_w};
            EXT_Z16:  imm_o = {{PAD_IMM{1'b0}}, low_w};
            EXT_HI16: imm_o = W_OUT'(low_w) << W_IMM;
            EXT_S26:  imm_o = {{PAD_OFF{raw_i[W_OFF-1]}}, raw_i};
            default:  imm_o = '0;
        endcase
    end

endmodule

// File: rtl/isd_decoder.sv
module isd_decoder
    import isd_pkg::*;
#(
    parameter int unsigned LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   instr_i,
    output logic [RIDX_W-1:0] wr_idx_o,
    output logic [RIDX_W-1:0] src_a_idx_o,
    output logic [RIDX_W-1:0] src_b_idx_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [ALU_W-1:0]  alu_op_o,
    output logic              use_imm_o,
    output logic              reg_we_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [FLOW_W-1:0] flow_o,
    output logic              illegal_o
);

    localparam int unsigned OPC_LSB = XLEN - OPC_W;
    localparam int unsigned RD_LSB  = OPC_LSB - RIDX_W;
    localparam int unsigned RS_LSB  = RD_LSB - RIDX_W;
    localparam int unsigned RT_LSB  = RS_LSB - RIDX_W;

    logic [OPC_W-1:0]  f_opc;
    logic [RIDX_W-1:0] f_rd;
    logic [RIDX_W-1:0] f_rs;
    logic [RIDX_W-1:0] f_rt;
    logic [FN_W-1:0]   f_fn;
    logic [OFF_W-1:0]  f_raw;

    assign f_opc = instr_i[XLEN-1:OPC_LSB];
    assign f_rd  = instr_i[OPC_LSB-1:RD_LSB];
    assign f_rs  = instr_i[RD_LSB-1:RS_LSB];
    assign f_rt  = instr_i[RS_LSB-1:RT_LSB];
    assign f_fn  = instr_i[FN_W-1:0];
    assign f_raw = instr_i[OFF_W-1:0];

    ctrl_t           ctrl;
    logic [XLEN-1:0] imm_ext;

    isd_op_lookup u_lookup (
        .opc_i  (f_opc),
        .fn_i   (f_fn),
        .ctrl_o (ctrl)
    );

    isd_imm_ext #(
        .W_OUT (XLEN),
        .W_IMM (IMM_W),
        .W_OFF (OFF_W)
    ) u_ext (
        .raw_i (f_raw),
        .ext_i (ctrl.ext),
        .imm_o (imm_ext)
    );

    dec_t dec_d;
    dec_t dec_q;

    always_comb begin
        dec_d = '0;
        if (ctrl.legal) begin
            dec_d.sa_idx = ctrl.sa_use ? f_rs : '0;
            case (ctrl.sb)
                SB_RT:   dec_d.sb_idx = f_rt;
                SB_RD:   dec_d.sb_idx = f_rd;
                default: dec_d.sb_idx = '0;
            endcase
            case (ctrl.wd)
                WD_RD:   dec_d.wr_idx = f_rd;
                WD_LINK: dec_d.wr_idx = RIDX_W'(LINK_REG);
                default: dec_d.wr_idx = '0;
            endcase
            dec_d.we      = (ctrl.wd != WD_NONE) && (dec_d.wr_idx != '0);
            dec_d.imm     = imm_ext;
            dec_d.alu     = ctrl.alu;
            dec_d.use_imm = ctrl.use_imm;
            dec_d.mrd     = ctrl.mrd;
            dec_d.mwr     = ctrl.mwr;
            dec_d.flow    = ctrl.flow;
        end else begin
            dec_d.illegal = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign wr_idx_o    = dec_q.wr_idx;
    assign src_a_idx_o = dec_q.sa_idx;
    assign src_b_idx_o = dec_q.sb_idx;
    assign imm_o       = dec_q.imm;
    assign alu_op_o    = dec_q.alu;
    assign use_imm_o   = dec_q.use_imm;
    assign reg_we_o    = dec_q.we;
    assign mem_rd_o    = dec_q.mrd;
    assign mem_wr_o    = dec_q.mwr;
    assign flow_o      = dec_q.flow;
    assign illegal_o   = dec_q.illegal;

endmodule

// File: rtl/isd_decoder_chk.sv
module isd_decoder_chk
    import isd_pkg::*;
#(
    parameter int unsigned LINK_REG = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPC_W-1:0]  op_i,
    input logic [RIDX_W-1:0] rd_fld_i,
    input logic [RIDX_W-1:0] wr_idx_o,
    input logic [RIDX_W-1:0] src_b_idx_o,
    input logic [XLEN-1:0]   imm_o,
    input logic              reg_we_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [FLOW_W-1:0] flow_o,
    input logic              illegal_o
);

    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!reg_we_o && !mem_rd_o && !mem_wr_o));

    a_r12_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (wr_idx_o != '0));

    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    a_r9_link_target: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 6'h03) |->
            (reg_we_o && wr_idx_o == RIDX_W'(LINK_REG) && flow_o == 3'd3));

    a_r7_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 6'h2B) |->
            (src_b_idx_o == $past(rd_fld_i) && !reg_we_o && mem_wr_o));

    a_r4_logic_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 6'h0C) |-> (imm_o[XLEN-1:IMM_W] == '0));

    a_r10_jr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 6'h12) |->
            (!reg_we_o && imm_o == '0 && flow_o == 3'd4));

    a_r8_branch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 6'h04) |-> (flow_o == 3'd1 && !reg_we_o));

endmodule

bind isd_decoder isd_decoder_chk #(.LINK_REG(LINK_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (instr_i[31:26]),
    .rd_fld_i    (instr_i[25:21]),
    .wr_idx_o    (wr_idx_o),
    .src_b_idx_o (src_b_idx_o),
    .imm_o       (imm_o),
    .reg_we_o    (reg_we_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .flow_o      (flow_o),
    .illegal_o   (illegal_o)
);

// File: tb/isd_decoder_tb.sv
module isd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;

    logic [4:0]  wr_idx, sa_idx, sb_idx;
    logic [31:0] imm;
    logic [3:0]  alu;
    logic        use_imm, we, mrd, mwr, illegal;
    logic [2:0]  flow;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    isd_decoder u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_i     (instr),
        .wr_idx_o    (wr_idx),
        .src_a_idx_o (sa_idx),
        .src_b_idx_o (sb_idx),
        .imm_o       (imm),
        .alu_op_o    (alu),
        .use_imm_o   (use_imm),
        .reg_we_o    (we),
        .mem_rd_o    (mrd),
        .mem_wr_o    (mwr),
        .flow_o      (flow),
        .illegal_o   (illegal)
    );

    // observed fields: wr, srcA, srcB, imm, alu, use_imm, we, mem_rd, mem_wr, flow, illegal
    logic [58:0] obs;
    assign obs = {wr_idx, sa_idx, sb_idx, imm, alu, use_imm, we, mrd, mwr, flow, illegal};

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] ins;
        logic [58:0] exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        // R2 add
        {4'd2, {6'h00,5'd3,5'd4,5'd5,11'h020}, {5'd3,5'd4,5'd5,32'h0,4'd1,1'b0,1'b1,2'b00,3'd0,1'b0}},
        // R2 mul
        {4'd2, {6'h00,5'd7,5'd1,5'd2,11'h030}, {5'd7,5'd1,5'd2,32'h0,4'd6,1'b0,1'b1,2'b00,3'd0,1'b0}},
        // R2 sra
        {4'd2, {6'h00,5'd9,5'd10,5'd11,11'h007}, {5'd9,5'd10,5'd11,32'h0,4'd13,1'b0,1'b1,2'b00,3'd0,1'b0}},
        // R2 sle
        {4'd2, {6'h00,5'd1,5'd2,5'd3,11'h02C}, {5'd1,5'd2,5'd3,32'h0,4'd10,1'b0,1'b1,2'b00,3'd0,1'b0}},
        // R2 sub
        {4'd2, {6'h00,5'd1,5'd2,5'd3,11'h022}, {5'd1,5'd2,5'd3,32'h0,4'd2,1'b0,1'b1,2'b00,3'd0,1'b0}},
        // R2 sll
        {4'd2, {6'h00,5'd4,5'd5,5'd6,11'h004}, {5'd4,5'd5,5'd6,32'h0,4'd11,1'b0,1'b1,2'b00,3'd0,1'b0}},
        // R3 R4 addi negative constant sign-extends
        {4'd3, {6'h08,5'd6,5'd7,16'hFFF0}, {5'd6,5'd7,5'd0,32'hFFFFFFF0,4'd1,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R4 andi zero-extends
        {4'd4, {6'h0C,5'd2,5'd3,16'h8001}, {5'd2,5'd3,5'd0,32'h00008001,4'd3,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R4 xori zero-extends
        {4'd4, {6'h0E,5'd4,5'd5,16'hFFFF}, {5'd4,5'd5,5'd0,32'h0000FFFF,4'd5,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R4 ori zero-extends
        {4'd4, {6'h0D,5'd1,5'd2,16'h8000}, {5'd1,5'd2,5'd0,32'h00008000,4'd4,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R3 slti sign-extends
        {4'd3, {6'h1A,5'd4,5'd5,16'h8000}, {5'd4,5'd5,5'd0,32'hFFFF8000,4'd9,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R3 seqi
        {4'd3, {6'h18,5'd1,5'd2,16'hFFFF}, {5'd1,5'd2,5'd0,32'hFFFFFFFF,4'd7,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R3 srli
        {4'd3, {6'h16,5'd8,5'd9,16'h0003}, {5'd8,5'd9,5'd0,32'h00000003,4'd12,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R5 load-high
        {4'd5, {6'h0F,5'd10,5'd11,16'h1234}, {5'd10,5'd0,5'd0,32'h12340000,4'd14,1'b1,1'b1,2'b00,3'd0,1'b0}},
        // R6 load word
        {4'd6, {6'h23,5'd12,5'd13,16'hFFFC}, {5'd12,5'd13,5'd0,32'hFFFFFFFC,4'd1,1'b1,1'b1,2'b10,3'd0,1'b0}},
        // R7 store word: data from destination field
        {4'd7, {6'h2B,5'd14,5'd15,16'h0008}, {5'd0,5'd15,5'd14,32'h00000008,4'd1,1'b1,1'b0,2'b01,3'd0,1'b0}},
        // R8 branch if zero
        {4'd8, {6'h04,5'd1,5'd2,16'hFFF8}, {5'd0,5'd2,5'd0,32'hFFFFFFF8,4'd0,1'b0,1'b0,2'b00,3'd1,1'b0}},
        // R8 branch if non-zero
        {4'd8, {6'h05,5'd0,5'd3,16'h0010}, {5'd0,5'd3,5'd0,32'h00000010,4'd0,1'b0,1'b0,2'b00,3'd2,1'b0}},
        // R9 jump negative offset
        {4'd9, {6'h02,26'h3FFFFFC}, {5'd0,5'd0,5'd0,32'hFFFFFFFC,4'd0,1'b0,1'b0,2'b00,3'd3,1'b0}},
        // R9 jump and link
        {4'd9, {6'h03,26'h0000100}, {5'd31,5'd0,5'd0,32'h00000100,4'd15,1'b0,1'b1,2'b00,3'd3,1'b0}},
        // R10 jump register ignores rd and constant
        {4'd10, {6'h12,5'd5,5'd6,16'h1234}, {5'd0,5'd6,5'd0,32'h0,4'd0,1'b0,1'b0,2'b00,3'd4,1'b0}},
        // R10 jump and link register
        {4'd10, {6'h13,5'd7,5'd8,16'hFFFF}, {5'd31,5'd8,5'd0,32'h0,4'd15,1'b0,1'b1,2'b00,3'd4,1'b0}},
        // R11 undefined major opcode
        {4'd11, {6'h3F,26'h155AAAA}, {5'd0,5'd0,5'd0,32'h0,4'd0,1'b0,1'b0,2'b00,3'd0,1'b1}},
        // R11 undefined function code
        {4'd11, {6'h00,5'd3,5'd4,5'd5,11'h021}, {5'd0,5'd0,5'd0,32'h0,4'd0,1'b0,1'b0,2'b00,3'd0,1'b1}},
        // R11 known function with a high function bit set
        {4'd11, {6'h00,5'd3,5'd4,5'd5,11'h420}, {5'd0,5'd0,5'd0,32'h0,4'd0,1'b0,1'b0,2'b00,3'd0,1'b1}},
        // R12 add into register 0 is suppressed
        {4'd12, {6'h00,5'd0,5'd4,5'd5,11'h020}, {5'd0,5'd4,5'd5,32'h0,4'd1,1'b0,1'b0,2'b00,3'd0,1'b0}},
        // R12 load into register 0 keeps the read strobe
        {4'd12, {6'h23,5'd0,5'd1,16'h0004}, {5'd0,5'd1,5'd0,32'h00000004,4'd1,1'b1,1'b0,2'b10,3'd0,1'b0}}
    };

    task automatic check(input string tag, input logic [58:0] exp);
        total++;
        if (obs !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, obs, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    localparam logic [31:0] W_ADD = {6'h00,5'd3,5'd4,5'd5,11'h020};
    localparam logic [58:0] E_ADD = {5'd3,5'd4,5'd5,32'h0,4'd1,1'b0,1'b1,2'b00,3'd0,1'b0};
    localparam logic [31:0] W_LW  = {6'h23,5'd12,5'd13,16'hFFFC};
    localparam logic [58:0] E_LW  = {5'd12,5'd13,5'd0,32'hFFFFFFFC,4'd1,1'b1,1'b1,2'b10,3'd0,1'b0};

    initial begin
        // R1: reset holds outputs at zero even with a word applied across edges
        instr = W_ADD;
        repeat (3) @(negedge clk);
        check("R1 reset clear", 59'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr = VEC[i].ins;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
        end

        // R1: one-edge latency, output holds until the next edge
        @(negedge clk);
        instr = W_ADD;
        @(negedge clk);
        check("R1 first word after edge", E_ADD);
        instr = W_LW;
        #2;
        check("R1 output held before edge", E_ADD);
        @(negedge clk);
        check("R1 second word after edge", E_LW);

        // R1: asynchronous reset clears mid-run without a clock edge
        @(posedge clk);
        #3;
        rst_n = 1'b0;
        #2;
        check("R1 async reset clear", 59'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 decode resumes after reset", E_LW);

        finish_run();
    end

endmodule